// File: doc/BRIEF.md
# Counter-Rotating Ring Transfer Arbiter

This block decides which node of a twelve-node on-chip ring may start a data transfer, on which of four unidirectional channels, and in which direction. Channels 0 and 1 carry data in the increasing node order (clockwise). Channels 2 and 3 carry data in the decreasing order (counter-clockwise). Each node holds a request naming its target node until the arbiter accepts it. The arbiter routes the request the short way round and selects a channel that can take it. It grants the request only if none of the ring links the transfer would use are held by a transfer already running on that channel. Several transfers may therefore share one channel when their paths do not touch.

After a grant, the arbiter follows the transfer through a fixed eight-beat lifetime, reports its completion and then frees the links. Each running transfer is held by a small tracker with two states. SLOT_FREE moves to SLOT_BUSY on a load (grant). SLOT_BUSY stays in SLOT_BUSY while its beat counter is non-zero and returns to SLOT_FREE on expiry, in the cycle after its last beat. Each channel owns three trackers and a start-spacing counter. A rotating pointer shares grants fairly among the nodes. The block does not move any data: it produces only the decisions and an occupancy view of each channel.

Top module: `ring_arbiter`

## Requirements
- R1: After reset no channel holds a transfer: `chan_seg_busy` and `chan_active` are zero, `gnt_valid` is low and no `req_ready` bit is set while no node requests.
- R2: With distance d = (dst - src) mod 12, a value of d from 1 to 5 is granted clockwise (`gnt_ccw`=0, channel 0 or 1, `gnt_hops`=d). A value of d from 7 to 11 is granted counter-clockwise (`gnt_ccw`=1, channel 2 or 3, `gnt_hops`=12-d).
- R3: At d = 6 the clockwise channels are tried first. If neither can take the transfer in that cycle, a counter-clockwise channel is granted in the same cycle with `gnt_hops`=6.
- R4: A request whose target equals its own node, or whose target is 12 or more, gets `req_err` and `req_ready` in the same cycle. It is never granted and changes no channel state.
- R5: Within a direction, the lower-numbered channel is preferred when both can accept.
- R6: A transfer is granted on a channel only if its links are disjoint from those of the transfers in flight there. Disjoint transfers share a channel, up to three at once.
- R7: After a start in cycle t, a channel accepts no new start before cycle t+3.
- R8: A transfer granted in cycle t holds its links during cycles t+1 to t+8. `done_src` pulses for its source node in cycle t+8, and the links can be granted again from cycle t+9.
- R9: A node that is the source of a running transfer is not granted as a source. A node that is the target of a running transfer is not granted as a target.
- R10: At most one transfer is granted per cycle. The winner is the first eligible node at or after a rotating pointer, and the pointer moves to the node after the winner.
- R11: Bit k of a channel's field in `chan_seg_busy` marks the link between node k and node (k+1) mod 12. Channel c uses bits [12c+11:12c]. `chan_active` field c (bits [2c+1:2c]) counts the transfers running on channel c.
- R12: `req_ready` for a granted node is high in the cycle of the grant, decided from that cycle's inputs. A blocked request keeps `req_ready` low until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 12 | Per-node request present |
| req_dst | input | 48 | Per-node target node, 4 bits per node, node n in bits [4n+3:4n] |
| req_ready | output | 12 | Per-node request accepted (granted or rejected) this cycle |
| req_err | output | 12 | Per-node request rejected as malformed |
| gnt_valid | output | 1 | A transfer is granted this cycle |
| gnt_node | output | 4 | Source node of the granted transfer |
| gnt_chan | output | 2 | Channel of the granted transfer |
| gnt_ccw | output | 1 | Granted transfer runs counter-clockwise |
| gnt_hops | output | 4 | Link count of the granted transfer |
| done_src | output | 12 | Per-source pulse in the last beat of its transfer |
| chan_seg_busy | output | 48 | Per-channel link occupancy, 12 bits per channel |
| chan_active | output | 8 | Per-channel count of running transfers, 2 bits per channel |

## Verification
The hardest situation to reach is a request that is eligible on every count but one. The collision rule must be seen to block a channel whose spacing window has already closed. The distance-six fallback must be seen to happen in the very cycle the clockwise channels refuse. The stimulus staggers starts one cycle apart on both clockwise channels so that each spacing counter and each link mask is in a known state. It then holds the blocked request and checks that it is refused in every cycle until the blocking transfer expires, and that it is accepted in exactly the expiry cycle.

// File: rtl/ring_arb_pkg.sv
package ring_arb_pkg;

    typedef enum logic [0:0] {
        SLOT_FREE = 1'b0,
        SLOT_BUSY = 1'b1
    } slot_state_e;

    // Forward distance from one node to another around a ring of given size.
    function automatic int ring_dist(input int from_n, input int to_n, input int nodes);
        return (to_n - from_n + nodes) % nodes;
    endfunction

endpackage

// File: rtl/ring_slot.sv
module ring_slot
    import ring_arb_pkg::*;
#(
    parameter int NODES = 12,
    parameter int BEATS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [$clog2(NODES)-1:0] ld_src,
    input  logic [$clog2(NODES)-1:0] ld_dst,
    input  logic [NODES-1:0]         ld_seg,
    output logic                     busy,
    output logic                     done,
    output logic [NODES-1:0]         seg,
    output logic [NODES-1:0]         src_oh,
    output logic [NODES-1:0]         dst_oh
);
    localparam int NW   = $clog2(NODES);
    localparam int CNTW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int LW   = $clog2(BEATS + 1);

    slot_state_e       state_q, state_d;
    logic [CNTW-1:0]   cnt_q;
    logic [NW-1:0]     src_q, dst_q;
    logic [NODES-1:0]  seg_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (load)         state_d = SLOT_BUSY;
            SLOT_BUSY: if (cnt_q == '0)  state_d = SLOT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            src_q <= '0;
            dst_q <= '0;
            seg_q <= '0;
        end else if (load) begin
            cnt_q <= CNTW'(BEATS - 1);
            src_q <= ld_src;
            dst_q <= ld_dst;
            seg_q <= ld_seg;
        end else if (state_q == SLOT_BUSY && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        busy   = (state_q == SLOT_BUSY);
        done   = busy && (cnt_q == '0);
        seg    = busy ? seg_q : '0;
        src_oh = busy ? (NODES'(1) << src_q) : '0;
        dst_oh = busy ? (NODES'(1) << dst_q) : '0;
    end

    // Independent lifetime counter for checking.
    logic [LW-1:0] life_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    life_q <= '0;
        else if (load) life_q <= LW'(1);
        else if (busy) life_q <= life_q + 1'b1;
    end

    AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy); // R6
    AST_LIFE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(life_q) == BEATS)); // R8
    AST_FREE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R8

endmodule

// File: rtl/ring_chan.sv
module ring_chan
    import ring_arb_pkg::*;
#(
    parameter int NODES   = 12,
    parameter int SLOTS   = 3,
    parameter int BEATS   = 8,
    parameter int SPACING = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [$clog2(NODES)-1:0]   st_src,
    input  logic [$clog2(NODES)-1:0]   st_dst,
    input  logic [NODES-1:0]           st_seg,
    output logic [NODES-1:0]           seg_busy,
    output logic                       can_start,
    output logic [NODES-1:0]           src_busy,
    output logic [NODES-1:0]           dst_busy,
    output logic [NODES-1:0]           done_src,
    output logic [$clog2(SLOTS+1)-1:0] active
);
    localparam int AW = $clog2(SLOTS + 1);
    localparam int GW = $clog2(SPACING + 1);

    logic [SLOTS-1:0] slot_busy, slot_done, slot_sel, slot_load;
    logic [NODES-1:0] slot_seg [SLOTS];
    logic [NODES-1:0] slot_src [SLOTS];
    logic [NODES-1:0] slot_dst [SLOTS];
    logic [GW-1:0]    gap_q;
    logic             have_free;

    // Lowest free tracker takes the next start.
    always_comb begin
        slot_sel  = '0;
        have_free = 1'b0;
        for (int s = 0; s < SLOTS; s++) begin
            if (!have_free && !slot_busy[s]) begin
                slot_sel[s] = 1'b1;
                have_free   = 1'b1;
            end
        end
    end

    assign slot_load = start ? slot_sel : '0;

    always_ff @(posedge clk) begin
        if (!rst_n)             gap_q <= '0;
        else if (start)         gap_q <= GW'(SPACING - 1);
        else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
    end

    assign can_start = (gap_q == '0) && have_free;

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic done_l;
        ring_slot #(.NODES(NODES), .BEATS(BEATS)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (slot_load[s]),
            .ld_src (st_src),
            .ld_dst (st_dst),
            .ld_seg (st_seg),
            .busy   (slot_busy[s]),
            .done   (done_l),
            .seg    (slot_seg[s]),
            .src_oh (slot_src[s]),
            .dst_oh (slot_dst[s])
        );
        assign slot_done[s] = done_l;
    end

    always_comb begin
        seg_busy = '0;
        src_busy = '0;
        dst_busy = '0;
        done_src = '0;
        active   = '0;
        for (int s = 0; s < SLOTS; s++) begin
            seg_busy = seg_busy | slot_seg[s];
            src_busy = src_busy | slot_src[s];
            dst_busy = dst_busy | slot_dst[s];
            if (slot_done[s]) done_src = done_src | slot_src[s];
            active   = active + AW'(slot_busy[s]);
        end
    end

    // Cycles since the last start, saturating, for the spacing check.
    logic [GW-1:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                    since_q <= GW'(SPACING);
        else if (start)                since_q <= GW'(1);
        else if (int'(since_q) < SPACING) since_q <= since_q + 1'b1;
    end

    AST_START_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ((st_seg & seg_busy) == '0)); // R6
    AST_START_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (int'(since_q) >= SPACING)); // R7
    AST_SLOT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (int'(active) < SLOTS)); // R6

endmodule

// File: rtl/ring_pick.sv
module ring_pick #(
    parameter int N = 12
) (
    input  logic [N-1:0]         req,
    input  logic [$clog2(N)-1:0] ptr,
    output logic [N-1:0]         gnt,
    output logic [$clog2(N)-1:0] idx,
    output logic                 any
);
    localparam int NW = $clog2(N);

    always_comb begin
        int cand;
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int k = 0; k < N; k++) begin
            cand = (int'(ptr) + k) % N;
            if (!any && req[cand]) begin
                any       = 1'b1;
                gnt[cand] = 1'b1;
                idx       = NW'(cand);
            end
        end
    end

endmodule

// File: rtl/ring_arbiter.sv
module ring_arbiter
    import ring_arb_pkg::*;
#(
    parameter int NODES   = 12,
    parameter int CHANS   = 4,
    parameter int SLOTS   = 3,
    parameter int BEATS   = 8,
    parameter int SPACING = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NODES-1:0]                   req_valid,
    input  logic [NODES*$clog2(NODES)-1:0]     req_dst,
    output logic [NODES-1:0]                   req_ready,
    output logic [NODES-1:0]                   req_err,
    output logic                               gnt_valid,
    output logic [$clog2(NODES)-1:0]           gnt_node,
    output logic [$clog2(CHANS)-1:0]           gnt_chan,
    output logic                               gnt_ccw,
    output logic [$clog2(NODES)-1:0]           gnt_hops,
    output logic [NODES-1:0]                   done_src,
    output logic [CHANS*NODES-1:0]             chan_seg_busy,
    output logic [CHANS*$clog2(SLOTS+1)-1:0]   chan_active
);
    localparam int NW   = $clog2(NODES);
    localparam int CW   = $clog2(CHANS);
    localparam int AW   = $clog2(SLOTS + 1);
    localparam int HALF = CHANS / 2;
    localparam int MAXH = NODES / 2;

    function automatic logic [NODES-1:0] span(input int first, input int len);
        logic [NODES-1:0] m;
        m = '0;
        for (int k = 0; k < NODES; k++)
            if (k < len) m[(first + k) % NODES] = 1'b1;
        return m;
    endfunction

    // Channel state
    logic [NODES-1:0] ch_seg [CHANS];
    logic [NODES-1:0] ch_src [CHANS];
    logic [NODES-1:0] ch_dst [CHANS];
    logic [NODES-1:0] ch_done [CHANS];
    logic [AW-1:0]    ch_act [CHANS];
    logic [CHANS-1:0] ch_can, ch_start;
    logic [NODES-1:0] src_busy, dst_busy;

    always_comb begin
        src_busy = '0;
        dst_busy = '0;
        done_src = '0;
        for (int c = 0; c < CHANS; c++) begin
            src_busy = src_busy | ch_src[c];
            dst_busy = dst_busy | ch_dst[c];
            done_src = done_src | ch_done[c];
        end
    end

    // Per-node routing and eligibility
    logic [NODES-1:0] node_ok, node_bad, node_ccw;
    logic [CW-1:0]    node_chan [NODES];
    logic [NW-1:0]    node_hops [NODES];
    logic [NODES-1:0] node_seg  [NODES];

    for (genvar n = 0; n < NODES; n++) begin : g_node
        logic             ok_l, bad_l, ccw_l;
        logic [CW-1:0]    chan_l;
        logic [NW-1:0]    hops_l;
        logic [NODES-1:0] seg_l;

        always_comb begin
            int dv, d;
            logic found, dst_hit;
            logic [NODES-1:0] cw_seg, ccw_seg;
            dv      = int'(req_dst[n*NW +: NW]);
            bad_l   = (dv >= NODES) || (dv == n);
            d       = bad_l ? 0 : ring_dist(n, dv, NODES);
            cw_seg  = span(n, d);
            ccw_seg = span(dv, NODES - d);
            dst_hit = |(dst_busy & (NODES'(1) << dv));
            found   = 1'b0;
            chan_l  = '0;
            ccw_l   = 1'b0;
            hops_l  = '0;
            seg_l   = '0;
            if (!bad_l && d <= MAXH) begin
                for (int c = 0; c < HALF; c++) begin
                    if (!found && ch_can[c] && ((ch_seg[c] & cw_seg) == '0)) begin
                        found  = 1'b1;
                        chan_l = CW'(c);
                        hops_l = NW'(d);
                        seg_l  = cw_seg;
                    end
                end
            end
            if (!bad_l && (NODES - d) <= MAXH) begin
                for (int c = HALF; c < CHANS; c++) begin
                    if (!found && ch_can[c] && ((ch_seg[c] & ccw_seg) == '0)) begin
                        found  = 1'b1;
                        chan_l = CW'(c);
                        ccw_l  = 1'b1;
                        hops_l = NW'(NODES - d);
                        seg_l  = ccw_seg;
                    end
                end
            end
            ok_l = req_valid[n] && !bad_l && found && !src_busy[n] && !dst_hit;
        end

        assign node_ok[n]   = ok_l;
        assign node_bad[n]  = bad_l;
        assign node_ccw[n]  = ccw_l;
        assign node_chan[n] = chan_l;
        assign node_hops[n] = hops_l;
        assign node_seg[n]  = seg_l;
    end

    // Fair selection
    logic [NW-1:0]    rr_q, pick_idx;
    logic [NODES-1:0] pick_gnt;
    logic             pick_any;

    ring_pick #(.N(NODES)) u_pick (
        .req (node_ok),
        .ptr (rr_q),
        .gnt (pick_gnt),
        .idx (pick_idx),
        .any (pick_any)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        rr_q <= '0;
        else if (pick_any) rr_q <= (int'(pick_idx) == NODES - 1) ? '0 : pick_idx + 1'b1;
    end

    logic [NW-1:0] win_dst;
    always_comb begin
        gnt_valid = pick_any;
        gnt_node  = pick_idx;
        gnt_chan  = node_chan[pick_idx];
        gnt_ccw   = pick_any && node_ccw[pick_idx];
        gnt_hops  = pick_any ? node_hops[pick_idx] : '0;
        win_dst   = req_dst[pick_idx*NW +: NW];
        req_err   = req_valid & node_bad;
        req_ready = req_err | pick_gnt;
    end

    for (genvar c = 0; c < CHANS; c++) begin : g_chan
        assign ch_start[c] = pick_any && (gnt_chan == CW'(c));

        ring_chan #(.NODES(NODES), .SLOTS(SLOTS), .BEATS(BEATS), .SPACING(SPACING)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (ch_start[c]),
            .st_src    (pick_idx),
            .st_dst    (win_dst),
            .st_seg    (node_seg[pick_idx]),
            .seg_busy  (ch_seg[c]),
            .can_start (ch_can[c]),
            .src_busy  (ch_src[c]),
            .dst_busy  (ch_dst[c]),
            .done_src  (ch_done[c]),
            .active    (ch_act[c])
        );

        assign chan_seg_busy[c*NODES +: NODES] = ch_seg[c];
        assign chan_active[c*AW +: AW]         = ch_act[c];
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready & ~req_err)); // R10
    AST_ERR_NOT_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_err & pick_gnt) == '0); // R4
    AST_HOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> (gnt_hops != '0 && int'(gnt_hops) <= MAXH)); // R2
    AST_DIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> ((int'(gnt_chan) >= HALF) == gnt_ccw)); // R5
    AST_SRC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_valid |-> !src_busy[gnt_node]); // R9

endmodule

// File: tb/ring_arbiter_tb_top.sv
module ring_arbiter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] req_valid = '0;
    logic [47:0] req_dst = '0;
    logic [11:0] req_ready, req_err, done_src;
    logic        gnt_valid, gnt_ccw;
    logic [3:0]  gnt_node, gnt_hops;
    logic [1:0]  gnt_chan;
    logic [47:0] chan_seg_busy;
    logic [7:0]  chan_active;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ring_arbiter dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dst(req_dst),
        .req_ready(req_ready), .req_err(req_err), .gnt_valid(gnt_valid),
        .gnt_node(gnt_node), .gnt_chan(gnt_chan), .gnt_ccw(gnt_ccw),
        .gnt_hops(gnt_hops), .done_src(done_src), .chan_seg_busy(chan_seg_busy),
        .chan_active(chan_active)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_req(input int node, input int dst);
        req_valid[node] = 1'b1;
        req_dst[node*4 +: 4] = 4'(dst);
        #1;
    endtask

    task automatic clr_req(input int node);
        req_valid[node] = 1'b0;
        #1;
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    function automatic int seg_of(input int ch);
        return int'(chan_seg_busy[ch*12 +: 12]);
    endfunction

    function automatic int act_of(input int ch);
        return int'(chan_active[ch*2 +: 2]);
    endfunction

    task automatic wait_idle;
        repeat (12) tick();
    endtask

    task automatic chk_grant(input string tag, input int node, input int ch, input int ccw, input int hops);
        chk({tag, " gnt_valid"}, int'(gnt_valid), 1);
        chk({tag, " gnt_node"}, int'(gnt_node), node);
        chk({tag, " gnt_chan"}, int'(gnt_chan), ch);
        chk({tag, " gnt_ccw"}, int'(gnt_ccw), ccw);
        chk({tag, " gnt_hops"}, int'(gnt_hops), hops);
        chk({tag, " req_ready"}, int'(req_ready[node]), 1);
    endtask

    task automatic t_reset;
        chk("R1 gnt_valid", int'(gnt_valid), 0);
        chk("R1 seg busy", int'(chan_seg_busy != '0), 0);
        chk("R1 active", int'(chan_active), 0);
        chk("R1 req_ready", int'(req_ready), 0);
    endtask

    task automatic t_cw_lifetime;
        set_req(0, 3);
        chk_grant("R2 R12 cw short", 0, 0, 0, 3);
        tick(); clr_req(0);
        chk("R11 ch0 links 0..2", seg_of(0), 12'h007);
        chk("R11 ch0 active", act_of(0), 1);
        for (int k = 1; k <= 9; k++) begin
            chk($sformatf("R8 done at cycle %0d", k), int'(done_src[0]), (k == 8) ? 1 : 0);
            if (k == 9) chk("R8 links freed", seg_of(0), 0);
            tick();
        end
        wait_idle();
    endtask

    task automatic t_ccw;
        set_req(1, 10);
        chk_grant("R2 ccw short", 1, 2, 1, 3);
        tick(); clr_req(1);
        chk("R11 ch2 links 10,11,0", seg_of(2), 12'hC01);
        wait_idle();
    endtask

    task automatic t_half_ring;
        set_req(2, 8);
        chk_grant("R3 six first cw", 2, 0, 0, 6);
        tick(); clr_req(2); set_req(3, 9);
        chk_grant("R5 second cw channel", 3, 1, 0, 6);
        tick(); clr_req(3); set_req(4, 10);
        chk_grant("R3 six fallback ccw", 4, 2, 1, 6);
        tick(); clr_req(4);
        chk("R3 ch2 links", seg_of(2), 12'hC0F);
        wait_idle();
    endtask

    task automatic t_spacing_share;
        set_req(0, 2);
        chk_grant("R7 first", 0, 0, 0, 2);
        tick(); clr_req(0); set_req(5, 7);
        chk_grant("R7 ch0 spaced, ch1 used", 5, 1, 0, 2);
        tick(); clr_req(5); set_req(8, 10);
        chk("R7 both cw spaced", int'(gnt_valid), 0);
        chk("R12 held not ready", int'(req_ready[8]), 0);
        tick();
        chk_grant("R7 R6 shared at t+3", 8, 0, 0, 2);
        tick(); clr_req(8);
        chk("R6 two on ch0", act_of(0), 2);
        chk("R11 ch0 union", seg_of(0), 12'h303);
        wait_idle();
    endtask

    task automatic t_collision;
        set_req(0, 4);
        chk_grant("R6 setup a", 0, 0, 0, 4);
        tick(); clr_req(0); set_req(1, 3);
        chk_grant("R6 setup b", 1, 1, 0, 2);
        tick(); clr_req(1); set_req(2, 5);
        for (int k = 2; k <= 8; k++) begin
            chk($sformatf("R6 blocked cycle %0d", k), int'(gnt_valid), 0);
            tick();
        end
        chk_grant("R8 links reused", 2, 0, 0, 3);
        tick(); clr_req(2);
        wait_idle();
    endtask

    task automatic t_ports;
        set_req(0, 2);
        chk_grant("R9 setup", 0, 0, 0, 2);
        tick(); clr_req(0); set_req(5, 2); set_req(0, 4);
        for (int k = 1; k <= 8; k++) begin
            chk($sformatf("R9 port busy cycle %0d", k), int'(gnt_valid), 0);
            tick();
        end
        chk_grant("R9 R10 target freed", 5, 2, 1, 3);
        tick(); clr_req(5);
        chk_grant("R9 source freed", 0, 0, 0, 4);
        tick(); clr_req(0);
        wait_idle();
    endtask

    task automatic t_errors;
        set_req(3, 3); set_req(4, 13); set_req(6, 7);
        chk("R4 err self", int'(req_err[3]), 1);
        chk("R4 ready self", int'(req_ready[3]), 1);
        chk("R4 err range", int'(req_err[4]), 1);
        chk("R4 good not err", int'(req_err[6]), 0);
        chk_grant("R4 good granted", 6, 0, 0, 1);
        tick(); clr_req(3); clr_req(4); clr_req(6);
        chk("R4 only one running", int'(chan_active), 1);
        wait_idle();
    endtask

    task automatic t_round_robin;
        set_req(1, 2); set_req(9, 10);
        chk_grant("R10 pointer past 6", 9, 0, 0, 1);
        chk("R10 loser not ready", int'(req_ready[1]), 0);
        tick(); clr_req(9);
        chk_grant("R10 next", 1, 1, 0, 1);
        tick(); clr_req(1);
        wait_idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_cw_lifetime();
        t_ccw();
        t_half_ring();
        t_spacing_share();
        t_collision();
        t_ports();
        t_errors();
        t_round_robin();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule